// File: doc/BRIEF.md
# Boot and Exception Vector Fetch Sequencer

This block fetches entries from a table of 32-bit words that starts at address zero. When reset is released it performs a fixed two-step boot. It first reads word 0 and loads that value into the main stack pointer. It then reads word 1, whose value is the address where execution starts. When an exception number is accepted, it reads the single table word at the exception number times four and delivers that word as the handler address.

Every table entry other than the stack pointer carries a state flag in its least significant bit. The program counter receives the entry with that bit cleared. An entry whose flag is zero is not a valid execution state, so the block raises a fault flag in the same cycle as the program counter load. Reads use a simple handshake: the block holds a request and an address until a one-cycle valid returns the data. The block does not prioritise exceptions, stack registers or fetch instructions.

Top module: `vector_fetch_seq`

## Requirements
- R1: While reset is asserted, `rd_req`, `sp_load`, `pc_load`, `vec_fault`, `seq_done` and `exc_ready` are all 0.
- R2: After reset is released, the first read goes to address 0x00000000. The returned word is presented on `sp_value` with bits [1:0] forced to 0, during a single-cycle `sp_load` pulse.
- R3: The second boot read goes to address 0x00000004. It is issued only after the `sp_load` pulse. Its word is delivered on `pc_value` with bit 0 cleared, during a single-cycle `pc_load` pulse (0x000000C1 gives 0x000000C0).
- R4: An accepted exception number n causes one read at address n*4, for example 8 for n=2 and 0x40 for n=16. The word is delivered on `pc_value` with bit 0 cleared, during a `pc_load` pulse.
- R5: When a delivered program-counter word has bit 0 equal to 0, `vec_fault` is 1 in the `pc_load` cycle. When bit 0 is 1, `vec_fault` stays 0.
- R6: `seq_done` pulses in exactly the cycles where `pc_load` pulses. `sp_load` and `pc_load` are never high together.
- R7: `exc_ready` is 1 only when no fetch is in progress. An `exc_req` presented while `exc_ready` is 0 is held off. It is accepted at the first clock edge where the block is idle, and its read follows the current fetch.
- R8: `rd_req` and `rd_addr` stay steady until a cycle with `rd_valid` high, whatever the read latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Exception number is offered |
| exc_num | input | 6 | Exception number to fetch |
| exc_ready | output | 1 | Block idle, an offered number is taken this edge |
| rd_req | output | 1 | Read request, held until rd_valid |
| rd_addr | output | 32 | Read word address |
| rd_valid | input | 1 | Read data valid, one cycle |
| rd_data | input | 32 | Read data |
| sp_load | output | 1 | Stack pointer load strobe |
| sp_value | output | 32 | Stack pointer value, word aligned |
| pc_load | output | 1 | Program counter load strobe |
| pc_value | output | 32 | Program counter value, bit 0 cleared |
| vec_fault | output | 1 | Delivered entry had an invalid state flag |
| seq_done | output | 1 | Fetch sequence finished |

## Verification
Each load strobe appears in the cycle after the edge that samples `rd_valid`. The second boot read starts two cycles after word 0 returns, because a one-cycle gap carries the stack pointer strobe. An exception read starts in the cycle after the edge that accepts the request. The bench memory model answers after a programmable number of cycles. At that point it compares `rd_addr` with an address queue filled by the driver tasks. A monitor samples at the falling edge and pops each strobe's expected value from a result queue, so every result is checked in the exact cycle it is due, whatever the latency. The model also checks that the stack pointer strobe has already been seen when it answers the address-4 boot read.

// File: rtl/vfetch_pkg.sv
package vfetch_pkg;
    localparam int unsigned VF_DW = 32;

    typedef enum logic [2:0] {
        ST_START,
        ST_SP,
        ST_GAP,
        ST_PC,
        ST_EXC,
        ST_IDLE
    } vf_state_e;

    typedef struct packed {
        vf_state_e        st;
        logic [VF_DW-1:0] addr;
        logic             sp_load;
        logic [VF_DW-1:0] sp_val;
        logic             pc_load;
        logic [VF_DW-1:0] pc_val;
        logic             fault;
        logic             done;
    } vf_regs_t;
endpackage

// File: rtl/vfetch_addr_gen.sv
module vfetch_addr_gen
    import vfetch_pkg::*;
#(
    parameter int unsigned NUM_W = 6,
    parameter logic [VF_DW-1:0] BASE = '0
) (
    input  logic [NUM_W-1:0] num,
    output logic [VF_DW-1:0] addr
);
    localparam int unsigned PAD_W = VF_DW - NUM_W - 2;

    always_comb begin
        addr = BASE + {{PAD_W{1'b0}}, num, 2'b00};
    end
endmodule

// File: rtl/vfetch_word_fmt.sv
module vfetch_word_fmt
    import vfetch_pkg::*;
(
    input  logic [VF_DW-1:0] word,
    output logic [VF_DW-1:0] sp_word,
    output logic [VF_DW-1:0] pc_word,
    output logic             state_ok
);
    always_comb begin
        sp_word  = {word[VF_DW-1:2], 2'b00};
        pc_word  = {word[VF_DW-1:1], 1'b0};
        state_ok = word[0];
    end
endmodule

// File: rtl/vfetch_ctrl.sv
module vfetch_ctrl
    import vfetch_pkg::*;
#(
    parameter logic [VF_DW-1:0] BASE = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exc_req,
    input  logic [VF_DW-1:0] exc_addr,
    output logic             exc_ready,
    output logic             rd_req,
    output logic [VF_DW-1:0] rd_addr,
    input  logic             rd_valid,
    input  logic [VF_DW-1:0] sp_word,
    input  logic [VF_DW-1:0] pc_word,
    input  logic             state_ok,
    output logic             sp_load,
    output logic [VF_DW-1:0] sp_value,
    output logic             pc_load,
    output logic [VF_DW-1:0] pc_value,
    output logic             vec_fault,
    output logic             seq_done
);
    localparam logic [VF_DW-1:0] WORD1 = BASE + VF_DW'(4);

    vf_regs_t q, d;

    always_comb begin
        d         = q;
        d.sp_load = 1'b0;
        d.pc_load = 1'b0;
        d.fault   = 1'b0;
        d.done    = 1'b0;
        case (q.st)
            ST_START: begin
                d.st   = ST_SP;
                d.addr = BASE;
            end
            ST_SP: begin
                if (rd_valid) begin
                    d.sp_load = 1'b1;
                    d.sp_val  = sp_word;
                    d.st      = ST_GAP;
                end
            end
            ST_GAP: begin
                d.st   = ST_PC;
                d.addr = WORD1;
            end
            ST_PC, ST_EXC: begin
                if (rd_valid) begin
                    d.pc_load = 1'b1;
                    d.pc_val  = pc_word;
                    d.fault   = !state_ok;
                    d.done    = 1'b1;
                    d.st      = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (exc_req) begin
                    d.addr = exc_addr;
                    d.st   = ST_EXC;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_START, default: '0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        rd_req    = (q.st == ST_SP) || (q.st == ST_PC) || (q.st == ST_EXC);
        rd_addr   = q.addr;
        exc_ready = rst_n && (q.st == ST_IDLE);
        sp_load   = q.sp_load;
        sp_value  = q.sp_val;
        pc_load   = q.pc_load;
        pc_value  = q.pc_val;
        vec_fault = q.fault;
        seq_done  = q.done;
    end

    // R2: stack pointer value delivered word aligned
    assert_sp_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sp_load |-> (sp_value[1:0] == 2'b00));

    // R3: the word-1 boot read starts right after the stack pointer strobe
    assert_boot_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_PC && $past(q.st) != ST_PC) |-> $past(sp_load));

    // R5: fault flag only accompanies a program counter load
    assert_fault_with_pc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_fault |-> pc_load);

    // R6: done matches the program counter strobe, strobes exclusive
    assert_done_pc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done == pc_load) && !(sp_load && pc_load));

    // R7: no new request is taken while a read is outstanding
    assert_ready_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        exc_ready |-> !rd_req);

    // R8: request and address held until data arrives
    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));
endmodule

// File: rtl/vector_fetch_seq.sv
module vector_fetch_seq
    import vfetch_pkg::*;
#(
    parameter int unsigned NUM_W = 6,
    parameter logic [VF_DW-1:0] BASE = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exc_req,
    input  logic [NUM_W-1:0] exc_num,
    output logic             exc_ready,
    output logic             rd_req,
    output logic [VF_DW-1:0] rd_addr,
    input  logic             rd_valid,
    input  logic [VF_DW-1:0] rd_data,
    output logic             sp_load,
    output logic [VF_DW-1:0] sp_value,
    output logic             pc_load,
    output logic [VF_DW-1:0] pc_value,
    output logic             vec_fault,
    output logic             seq_done
);
    logic [VF_DW-1:0] exc_addr;
    logic [VF_DW-1:0] sp_word;
    logic [VF_DW-1:0] pc_word;
    logic             state_ok;

    vfetch_addr_gen #(.NUM_W(NUM_W), .BASE(BASE)) u_addr (
        .num  (exc_num),
        .addr (exc_addr)
    );

    vfetch_word_fmt u_fmt (
        .word     (rd_data),
        .sp_word  (sp_word),
        .pc_word  (pc_word),
        .state_ok (state_ok)
    );

    vfetch_ctrl #(.BASE(BASE)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .exc_req   (exc_req),
        .exc_addr  (exc_addr),
        .exc_ready (exc_ready),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .rd_valid  (rd_valid),
        .sp_word   (sp_word),
        .pc_word   (pc_word),
        .state_ok  (state_ok),
        .sp_load   (sp_load),
        .sp_value  (sp_value),
        .pc_load   (pc_load),
        .pc_value  (pc_value),
        .vec_fault (vec_fault),
        .seq_done  (seq_done)
    );
endmodule

// File: tb/vector_fetch_seq_test.sv
module vector_fetch_seq_test;
    typedef struct {
        bit          is_pc;
        logic [31:0] val;
        bit          flt;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_req = 1'b0;
    logic [5:0]  exc_num = '0;
    logic        exc_ready, rd_req, rd_valid = 1'b0;
    logic [31:0] rd_addr, rd_data = '0;
    logic        sp_load, pc_load, vec_fault, seq_done;
    logic [31:0] sp_value, pc_value;

    int    checks = 0;
    int    errors = 0;
    int    lat = 0;
    int    wait_cnt = 0;
    bit    sp_seen = 1'b0;
    bit    finished = 1'b0;
    logic [31:0] boot_sp_word = 32'h2000_8003;
    logic [31:0] boot_pc_word = 32'h0000_00C1;
    logic [31:0] addrq[$];
    exp_t  expq[$];

    always #2 clk = ~clk;

    vector_fetch_seq uut (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_num(exc_num),
        .exc_ready(exc_ready), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .sp_load(sp_load),
        .sp_value(sp_value), .pc_load(pc_load), .pc_value(pc_value),
        .vec_fault(vec_fault), .seq_done(seq_done)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp_v);
        end
    endtask

    function automatic logic [31:0] table_word(input logic [31:0] a);
        if (a == 32'h0) return boot_sp_word;
        if (a == 32'h4) return boot_pc_word;
        if (a == 32'h2C) return 32'h0000_1230;
        return 32'h0001_0001 | (a << 4);
    endfunction

    task automatic push_exc(input int n, input string req);
        exp_t e;
        logic [31:0] w;
        w = table_word(32'(n) * 4);
        addrq.push_back(32'(n) * 4);
        e.is_pc = 1'b1; e.val = w & ~32'h1; e.flt = !w[0]; e.req = req;
        expq.push_back(e);
    endtask

    task automatic push_boot();
        exp_t e;
        addrq.push_back(32'h0);
        addrq.push_back(32'h4);
        e.is_pc = 1'b0; e.val = boot_sp_word & ~32'h3; e.flt = 1'b0; e.req = "R2";
        expq.push_back(e);
        e.is_pc = 1'b1; e.val = boot_pc_word & ~32'h1; e.flt = !boot_pc_word[0]; e.req = "R3";
        expq.push_back(e);
    endtask

    task automatic do_exc(input int n, input string req);
        @(negedge clk);
        while (!exc_ready) @(negedge clk);
        push_exc(n, req);
        exc_req = 1'b1;
        exc_num = 6'(n);
        @(negedge clk);
        exc_req = 1'b0;
    endtask

    task automatic drain();
        @(negedge clk);
        while (expq.size() != 0 || !exc_ready) @(negedge clk);
        check(addrq.size() == 0, "R4", 32'(addrq.size()), 32'h0);
    endtask

    // memory model: answers after lat waiting cycles, checks the address
    initial begin
        forever begin
            @(negedge clk);
            if (rd_valid) begin
                rd_valid = 1'b0;
                wait_cnt = 0;
            end else if (rd_req) begin
                if (wait_cnt >= lat) begin
                    if (addrq.size() == 0) begin
                        check(1'b0, "R4", rd_addr, 32'hFFFF_FFFF);
                    end else begin
                        logic [31:0] ea;
                        ea = addrq.pop_front();
                        check(rd_addr == ea, "R4 address", rd_addr, ea);
                    end
                    if (rd_addr == 32'h4 && !exc_ready && expq.size() == 1 && !expq[0].is_pc == 1'b0
                        && expq[0].req == "R3")
                        check(sp_seen, "R3 order", 32'(sp_seen), 32'h1);
                    rd_data  = table_word(rd_addr);
                    rd_valid = 1'b1;
                end else begin
                    wait_cnt++;
                end
            end
        end
    end

    // monitor: pops expected items as strobes appear
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (sp_load || pc_load || seq_done) begin
                    check(seq_done == pc_load, "R6 done", 32'(seq_done), 32'(pc_load));
                    check(!(sp_load && pc_load), "R6 exclusive", 32'(sp_load), 32'h0);
                end
                if (sp_load || pc_load) begin
                    if (expq.size() == 0) begin
                        check(1'b0, "R4 unexpected strobe", pc_value, 32'h0);
                    end else begin
                        exp_t e;
                        e = expq.pop_front();
                        if (sp_load) begin
                            check(!e.is_pc, e.req, 32'h0, 32'h1);
                            check(sp_value == e.val, "R2 sp_value", sp_value, e.val);
                            sp_seen = 1'b1;
                        end else begin
                            check(e.is_pc, e.req, 32'h1, 32'h0);
                            check(pc_value == e.val, e.req, pc_value, e.val);
                            check(vec_fault == e.flt, "R5 fault", 32'(vec_fault), 32'(e.flt));
                            sp_seen = 1'b0;
                        end
                    end
                end else begin
                    check(!vec_fault, "R5 stray fault", 32'(vec_fault), 32'h0);
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: quiet outputs during reset
        repeat (3) @(negedge clk);
        check(!rd_req && !sp_load && !pc_load && !vec_fault && !seq_done && !exc_ready,
              "R1 reset", {26'h0, rd_req, sp_load, pc_load, vec_fault, seq_done, exc_ready}, 32'h0);
        // R2 / R3: boot with zero latency
        push_boot();
        rst_n = 1'b1;
        drain();
        // R4 / R5: exceptions at several latencies
        lat = 1;
        do_exc(2, "R4 nmi");
        drain();
        do_exc(16, "R4 irq0");
        drain();
        lat = 3;                                   // R8: long wait, address must stay
        do_exc(47, "R4 irq31");
        drain();
        do_exc(11, "R5 even entry");
        drain();
        lat = 0;
        do_exc(3, "R4 hardfault");
        drain();
        // R7: request offered while busy is held off, then served in order
        lat = 4;
        do_exc(14, "R7 first");
        exc_req = 1'b1;
        exc_num = 6'd15;
        push_exc(15, "R7 second");
        check(!exc_ready, "R7 busy", 32'(exc_ready), 32'h0);
        @(negedge clk);
        check(!exc_ready, "R7 busy", 32'(exc_ready), 32'h0);
        while (!exc_ready) @(negedge clk);
        @(negedge clk);
        exc_req = 1'b0;
        drain();
        // second boot: low sp bits forced, even start entry faults (R2, R3, R5)
        rst_n = 1'b0;
        boot_sp_word = 32'hFFFF_FFFE;
        boot_pc_word = 32'h0000_0100;
        lat = 2;
        repeat (2) @(negedge clk);
        check(!rd_req && !exc_ready, "R1 reset again", {30'h0, rd_req, exc_ready}, 32'h0);
        push_boot();
        rst_n = 1'b1;
        drain();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule